// File: doc/BRIEF.md
# NMI Edge Qualifier and Power-Mode Wake Controller

This block turns the raw non-maskable interrupt pin into a clean vector request for the instruction sequencer. The pin is synchronized with a short flop chain. A low-to-high change then has to be followed by a minimum run of high samples before it counts as a request. Shorter glitches are thrown away.

What happens to a qualified edge depends on the power mode at that moment. In run mode the block raises a pending request at once and presents the fixed 24-bit service vector. In idle mode it first pulses a wake signal for one cycle, so the clock logic can restore normal operation, and then raises the request. It also records that the return point is the instruction after the one that entered idle. In powerdown, and in the reserved mode code, the edge is dropped and nothing changes.

A request stays up until the sequencer acknowledges it. Only one request is ever held, so an edge that qualifies while one is pending or waking is lost.

Top module: `nmi_wake_ctrl`

The edge qualifier has three states:
- `QS_LOW`: armed, waiting for a high sample.
- `QS_COUNT`: counting consecutive high samples. A low sample returns it to `QS_LOW`. Reaching the minimum count qualifies the edge and moves it to `QS_HELD`.
- `QS_HELD`: waiting for the pin to go low, then back to `QS_LOW`.

The response sequencer has three states:
- `RS_QUIET`: nothing pending. A qualified edge moves it to `RS_PEND` in run mode or to `RS_WAKE` in idle mode, and is ignored in powerdown or the reserved mode.
- `RS_WAKE`: one cycle, always followed by `RS_PEND`.
- `RS_PEND`: request held until `ack_i`, which returns it to `RS_QUIET`.

## Requirements
- R1: While and after reset, with no qualified edge, `nmi_req_o`, `wake_o` and `resume_next_o` are 0 and `nmi_vec_o` is 0.
- R2: In run mode (`pmode_i` = 2'b00), a pin that is low and then sampled high on 3 consecutive rising clock edges raises `nmi_req_o` after the 5th rising edge, counting from the first edge that samples it high. `nmi_vec_o` then reads 24'hFF203E.
- R3: A high pulse sampled on only 1 or 2 consecutive edges never raises `nmi_req_o` or `wake_o`.
- R4: A pin held high yields one request only. A new request needs the pin to go low and then qualify again.
- R5: In idle mode (`pmode_i` = 2'b01), a qualified edge drives `wake_o` high for exactly one cycle, after the 5th edge. `nmi_req_o` rises in the following cycle.
- R6: In powerdown (`pmode_i` = 2'b10) or the reserved code 2'b11, a qualified edge changes none of the outputs.
- R7: `nmi_req_o` stays high until a cycle with `ack_i` high and is low after that edge. `nmi_vec_o` is 24'hFF203E whenever `nmi_req_o` is high and 0 otherwise.
- R8: An edge that qualifies while a request is waking or pending is not queued. No second request follows the acknowledge.
- R9: `resume_next_o` becomes 1 when an edge is accepted in idle mode and 0 when one is accepted in run mode. Otherwise it holds its value, including across ignored powerdown edges.
- R10: `ack_i` with no request pending has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears the synchronizer, the qualifier and the sequencer |
| nmi_pin_i | input | 1 | Raw asynchronous NMI pin |
| pmode_i | input | 2 | Power mode: 00 run, 01 idle, 10 powerdown, 11 reserved (treated as powerdown) |
| ack_i | input | 1 | Sequencer acknowledge of the pending request |
| nmi_req_o | output | 1 | Pending NMI vector request |
| nmi_vec_o | output | 24 | Service vector address while a request is pending, else 0 |
| wake_o | output | 1 | One-cycle pulse: leave idle mode |
| resume_next_o | output | 1 | Saved return point: 1 means resume after the idle-entry instruction |

## Verification
The checker watches the sequencer's handshake on every cycle:
- the request holds until acknowledged and drops after the acknowledge;
- the vector matches the request level;
- the wake pulse is one cycle long, is always followed by a request and always carries the saved return flag.

The input side can only be shown by the bench's scenarios:
- the pulse-width boundary (two samples rejected, three accepted);
- the exact latency through the synchronizer;
- the single request from a held level;
- dropped edges in powerdown and while a request is pending;
- the flag holding its value across ignored edges.

// File: rtl/nmi_wake_pkg.sv
package nmi_wake_pkg;

    typedef enum logic [1:0] {
        PM_RUN  = 2'b00,
        PM_IDLE = 2'b01,
        PM_DOWN = 2'b10,
        PM_RSVD = 2'b11
    } pmode_e;

    typedef enum logic [1:0] {
        QS_LOW   = 2'b00,
        QS_COUNT = 2'b01,
        QS_HELD  = 2'b10
    } qual_state_e;

    typedef enum logic [1:0] {
        RS_QUIET = 2'b00,
        RS_WAKE  = 2'b01,
        RS_PEND  = 2'b10
    } resp_state_e;

endpackage

// File: rtl/nmi_sync.sv
module nmi_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= 1'b0;
                    else        chain_q[g] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= 1'b0;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/nmi_width_qual.sv
module nmi_width_qual
    import nmi_wake_pkg::*;
#(
    parameter int MIN_HIGH = 3,
    localparam int CNT_W = $clog2(MIN_HIGH + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic qual_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(MIN_HIGH - 1);

    qual_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= QS_LOW;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            QS_LOW: begin
                if (level_i) begin
                    state_d = QS_COUNT;
                    cnt_d   = CNT_W'(1);
                end
            end
            QS_COUNT: begin
                if (!level_i) begin
                    state_d = QS_LOW;
                    cnt_d   = '0;
                end else if (cnt_q == LAST) begin
                    state_d = QS_HELD;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
            QS_HELD: begin
                if (!level_i) state_d = QS_LOW;
            end
            default: begin
                state_d = QS_LOW;
                cnt_d   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        qual_o = 1'b0;
        unique case (state_q)
            QS_COUNT: qual_o = level_i && (cnt_q == LAST);
            default:  qual_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/nmi_resp_fsm.sv
module nmi_resp_fsm
    import nmi_wake_pkg::*;
#(
    parameter int          VEC_W  = 24,
    parameter logic [VEC_W-1:0] VECTOR = 24'hFF203E
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             qual_i,
    input  logic [1:0]       pmode_i,
    input  logic             ack_i,
    output logic             req_o,
    output logic [VEC_W-1:0] vec_o,
    output logic             wake_o,
    output logic             resume_o
);
    resp_state_e state_q, state_d;
    pmode_e      mode;
    logic        resume_q;

    assign mode = pmode_e'(pmode_i);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RS_QUIET;
        else        state_q <= state_d;
    end

    // return-point flag: rewritten only when an edge is accepted
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resume_q <= 1'b0;
        end else if (state_q == RS_QUIET && qual_i) begin
            if (mode == PM_RUN)       resume_q <= 1'b0;
            else if (mode == PM_IDLE) resume_q <= 1'b1;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RS_QUIET: begin
                if (qual_i) begin
                    unique case (mode)
                        PM_RUN:  state_d = RS_PEND;
                        PM_IDLE: state_d = RS_WAKE;
                        PM_DOWN: state_d = RS_QUIET;
                        PM_RSVD: state_d = RS_QUIET;
                        default: state_d = RS_QUIET;
                    endcase
                end
            end
            RS_WAKE: state_d = RS_PEND;
            RS_PEND: begin
                if (ack_i) state_d = RS_QUIET;
            end
            default: state_d = RS_QUIET;
        endcase
    end

    // outputs
    always_comb begin
        req_o  = 1'b0;
        wake_o = 1'b0;
        vec_o  = '0;
        unique case (state_q)
            RS_WAKE: wake_o = 1'b1;
            RS_PEND: begin
                req_o = 1'b1;
                vec_o = VECTOR;
            end
            default: ;
        endcase
    end

    assign resume_o = resume_q;
endmodule

// File: rtl/nmi_wake_ctrl.sv
module nmi_wake_ctrl
    import nmi_wake_pkg::*;
#(
    parameter int               SYNC_STAGES = 2,
    parameter int               MIN_HIGH    = 3,
    parameter int               VEC_W       = 24,
    parameter logic [VEC_W-1:0] VECTOR      = 24'hFF203E
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             nmi_pin_i,
    input  logic [1:0]       pmode_i,
    input  logic             ack_i,
    output logic             nmi_req_o,
    output logic [VEC_W-1:0] nmi_vec_o,
    output logic             wake_o,
    output logic             resume_next_o
);
    logic pin_sync;
    logic edge_qual;

    nmi_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (nmi_pin_i),
        .sync_o  (pin_sync)
    );

    nmi_width_qual #(.MIN_HIGH(MIN_HIGH)) u_qual (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (pin_sync),
        .qual_o  (edge_qual)
    );

    nmi_resp_fsm #(.VEC_W(VEC_W), .VECTOR(VECTOR)) u_resp (
        .clk      (clk),
        .rst_n    (rst_n),
        .qual_i   (edge_qual),
        .pmode_i  (pmode_i),
        .ack_i    (ack_i),
        .req_o    (nmi_req_o),
        .vec_o    (nmi_vec_o),
        .wake_o   (wake_o),
        .resume_o (resume_next_o)
    );
endmodule

// File: rtl/nmi_wake_ctrl_chk.sv
module nmi_wake_ctrl_chk #(
    parameter int               VEC_W  = 24,
    parameter logic [VEC_W-1:0] VECTOR = 24'hFF203E
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ack_i,
    input logic             nmi_req_o,
    input logic [VEC_W-1:0] nmi_vec_o,
    input logic             wake_o,
    input logic             resume_next_o
);
    // R7: request holds until acknowledged
    p_hold_until_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_req_o && !ack_i |=> nmi_req_o);

    // R7: acknowledge drops the request
    p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_req_o && ack_i |=> !nmi_req_o);

    // R7: vector follows the request level
    p_vec_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_vec_o == (nmi_req_o ? VECTOR : '0));

    // R5: wake lasts one cycle and is followed by the request
    p_wake_then_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |=> nmi_req_o && !wake_o);

    // R5: wake and request never overlap
    p_wake_req_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wake_o, nmi_req_o}));

    // R9: waking from idle always carries the saved return point
    p_wake_resume_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> resume_next_o);

    // R9: flag only moves when a new request is accepted
    p_resume_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_req_o |=> $stable(resume_next_o));
endmodule

bind nmi_wake_ctrl nmi_wake_ctrl_chk #(.VEC_W(VEC_W), .VECTOR(VECTOR)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ack_i         (ack_i),
    .nmi_req_o     (nmi_req_o),
    .nmi_vec_o     (nmi_vec_o),
    .wake_o        (wake_o),
    .resume_next_o (resume_next_o)
);

// File: tb/nmi_wake_ctrl_tb.sv
module nmi_wake_ctrl_tb;
    localparam logic [23:0] VEC = 24'hFF203E;

    typedef struct {
        int    cyc;
        logic  req;
        logic  wake;
        logic  res;
        string tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        nmi_pin_i = 1'b0;
    logic [1:0]  pmode_i = 2'b00;
    logic        ack_i = 1'b0;
    logic        nmi_req_o;
    logic [23:0] nmi_vec_o;
    logic        wake_o;
    logic        resume_next_o;

    int   cyc = 0;
    int   n_checks = 0;
    int   n_fail = 0;
    logic done = 1'b0;
    exp_t sb[$];

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    nmi_wake_ctrl u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .nmi_pin_i     (nmi_pin_i),
        .pmode_i       (pmode_i),
        .ack_i         (ack_i),
        .nmi_req_o     (nmi_req_o),
        .nmi_vec_o     (nmi_vec_o),
        .wake_o        (wake_o),
        .resume_next_o (resume_next_o)
    );

    task automatic compare(string tag, logic rq, logic wk, logic rs);
        logic [23:0] ev;
        ev = rq ? VEC : 24'h0;
        n_checks++;
        if (nmi_req_o !== rq || wake_o !== wk || resume_next_o !== rs || nmi_vec_o !== ev) begin
            n_fail++;
            $display("FAIL %s cyc=%0d: req/wake/res/vec got %b%b%b %h expected %b%b%b %h",
                     tag, cyc, nmi_req_o, wake_o, resume_next_o, nmi_vec_o, rq, wk, rs, ev);
        end
    endtask

    // monitor: pop expected items as their cycle comes up
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].cyc <= cyc) begin
            exp_t e;
            e = sb.pop_front();
            if (e.cyc < cyc) begin
                n_checks++;
                n_fail++;
                $display("FAIL %s: missed slot got cyc %0d expected cyc %0d", e.tag, cyc, e.cyc);
            end else begin
                compare(e.tag, e.req, e.wake, e.res);
            end
        end
    end

    task automatic expect_at(int off, logic rq, logic wk, logic rs, string tag);
        exp_t e;
        e.cyc = cyc + off; e.req = rq; e.wake = wk; e.res = rs; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(int n);
        nmi_pin_i = 1'b1;
        step(n);
        nmi_pin_i = 1'b0;
    endtask

    task automatic ack_once();
        ack_i = 1'b1;
        step(1);
        ack_i = 1'b0;
    endtask

    initial begin
        step(3);
        compare("R1 in reset", 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;
        step(2);
        compare("R1 after reset", 1'b0, 1'b0, 1'b0);

        // R2: run mode, width 3
        pmode_i = 2'b00;
        expect_at(4, 1'b0, 1'b0, 1'b0, "R2 not yet");
        expect_at(5, 1'b1, 1'b0, 1'b0, "R2 request");
        pulse(3);
        step(4);
        expect_at(1, 1'b0, 1'b0, 1'b0, "R7 ack clears");
        ack_once();
        step(3);

        // R3: widths 2 and 1 rejected
        expect_at(5, 1'b0, 1'b0, 1'b0, "R3 width2");
        expect_at(7, 1'b0, 1'b0, 1'b0, "R3 width2 late");
        pulse(2);
        step(8);
        expect_at(5, 1'b0, 1'b0, 1'b0, "R3 width1");
        pulse(1);
        step(8);

        // R5: idle wake then request
        pmode_i = 2'b01;
        expect_at(5, 1'b0, 1'b1, 1'b1, "R5 wake");
        expect_at(6, 1'b1, 1'b0, 1'b1, "R5 req after wake");
        pulse(3);
        step(5);
        expect_at(1, 1'b0, 1'b0, 1'b1, "R9 flag held after ack");
        ack_once();
        step(3);

        // R6: powerdown and reserved ignore edges; R9 flag held
        pmode_i = 2'b10;
        expect_at(5, 1'b0, 1'b0, 1'b1, "R6 powerdown");
        expect_at(8, 1'b0, 1'b0, 1'b1, "R6 powerdown late");
        pulse(5);
        step(8);
        pmode_i = 2'b11;
        expect_at(6, 1'b0, 1'b0, 1'b1, "R6 reserved");
        pulse(5);
        step(8);

        // R4 + R9: held level gives one request, flag back to 0
        pmode_i = 2'b00;
        expect_at(5, 1'b1, 1'b0, 1'b0, "R4 held first req");
        nmi_pin_i = 1'b1;
        step(7);
        expect_at(1, 1'b0, 1'b0, 1'b0, "R7 ack held level");
        ack_once();
        expect_at(6, 1'b0, 1'b0, 1'b0, "R4 no repeat");
        step(8);
        nmi_pin_i = 1'b0;
        step(4);

        // R8: edge during pending not queued
        expect_at(5, 1'b1, 1'b0, 1'b0, "R8 first req");
        pulse(3);
        step(4);
        pulse(3);
        step(4);
        expect_at(1, 1'b0, 1'b0, 1'b0, "R8 ack");
        expect_at(4, 1'b0, 1'b0, 1'b0, "R8 not queued");
        ack_once();
        step(6);

        // R10: stray ack ignored, next edge works
        expect_at(1, 1'b0, 1'b0, 1'b0, "R10 stray ack");
        ack_once();
        expect_at(5, 1'b1, 1'b0, 1'b0, "R10 req after stray ack");
        pulse(3);
        step(4);
        ack_once();
        step(3);

        if (sb.size() != 0) begin
            n_checks++;
            n_fail++;
            $display("FAIL R1 scoreboard: got %0d leftover expected 0", sb.size());
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R1 watchdog: got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule